// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two signed two's-complement operands of parameter width `W` (4 to 16 bits) over several clock cycles. It uses one adder. One request runs through `W` identical steps. In each step the block looks at the low bit of the multiplier and at the bit that was examined just before it. From that pair it adds the multiplicand into the upper half of the accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole double-width accumulator right by one place and keeps the sign. The multiplier register rotates in a ring, so it still holds its original value when the request ends.

A host pulses `start` while the block is idle and presents both operands in that cycle. `busy` stays high while the steps run. A single-cycle `done` marks the cycle in which `product` first shows the full `2W`-bit signed result. The result then stays on `product` until the next accepted request. An optional front stage counts the changes between adjacent bits in each operand and uses the operand with fewer changes as the multiplier. This option does not change the result or the latency.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 is accepted: `busy` is 1 from the next cycle on.
- R3: Exactly `W` steps run. `done` is high in the cycle that follows the `W`-th clock edge after the accepting edge, and `busy` is low in that same cycle.
- R4: When `done` is high, `product` equals the `2W`-bit signed product of the operands captured at acceptance. This holds for 0, -1, the most positive value and the most negative value. For example, at `W`=4, 0010 times 1100 gives 11111000.
- R5: `done` is high for exactly one cycle per request.
- R6: While `busy` is 0 and no `start` arrives, `product` keeps its value and `done` stays low.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running request keeps its operands and its completion cycle.
- R8: With the fewer-changes selection turned on or off (parameter `PICK_FEWER` = 1 or 0), `product` and timing are identical. On a tie, the first operand `a_in` stays the multiplier.
- R9: A `start` that arrives in the cycle where `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| a_in | input | W | First signed operand |
| b_in | input | W | Second signed operand |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle completion marker |
| product | output | 2W | Signed double-width result |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench provokes this by raising `start` exactly in the `done` cycle. It then checks that the first result was shown intact and that the second request returns its own product after a full `W` steps. The bench also overlaps a `start` with a running request. It checks that neither the operands nor the completion cycle are disturbed.

// File: rtl/booth_pkg.sv
package booth_pkg;
   typedef enum logic [1:0] {
      BOP_HOLD = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;

   // pair = {current multiplier lsb, previously examined bit}
   function automatic booth_op_e booth_decode(input logic [1:0] pair);
      case (pair)
         2'b01:   return BOP_ADD;
         2'b10:   return BOP_SUB;
         default: return BOP_HOLD;
      endcase
   endfunction
endpackage

// File: rtl/booth_operand_sel.sv
module booth_operand_sel #(
   parameter int W          = 8,
   parameter bit PICK_FEWER = 1'b1
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W-1:0] mplier,
   output logic [W-1:0] mcand
);
   localparam int CW = $clog2(W);

   function automatic logic [CW-1:0] edge_count(input logic [W-1:0] v);
      logic [CW-1:0] n;
      n = '0;
      for (int i = 0; i < W-1; i++)
         n = n + CW'(v[i] ^ v[i+1]);
      return n;
   endfunction

   generate
      if (PICK_FEWER) begin : g_pick
         logic [CW-1:0] na, nb;
         logic          use_b;
         always_comb begin
            na     = edge_count(opa);
            nb     = edge_count(opb);
            use_b  = (nb < na);
            mplier = use_b ? opb : opa;
            mcand  = use_b ? opa : opb;
         end
      end else begin : g_fixed
         assign mplier = opa;
         assign mcand  = opb;
      end
   endgenerate
endmodule

// File: rtl/booth_step.sv
module booth_step
   import booth_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] u,
   input  logic [W-1:0] v,
   input  logic [W-1:0] x,
   input  logic         xm1,
   input  logic [W:0]   y_pos,
   input  logic [W:0]   y_neg,
   output logic [W-1:0] u_nx,
   output logic [W-1:0] v_nx,
   output logic [W-1:0] x_nx,
   output logic         xm1_nx
);
   booth_op_e  op;
   logic [W:0] u_g;
   logic [W:0] sum;

   always_comb begin
      op  = booth_decode({x[0], xm1});
      u_g = {u[W-1], u};
      case (op)
         BOP_ADD: sum = u_g + y_pos;
         BOP_SUB: sum = u_g + y_neg;
         default: sum = u_g;
      endcase
      // arithmetic right shift of guard:U:V; the guard bit is absorbed
      u_nx   = sum[W:1];
      v_nx   = {sum[0], v[W-1:1]};
      x_nx   = {x[0], x[W-1:1]};
      xm1_nx = x[0];
   end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step
);
   localparam int CNTW = $clog2(W + 1);
   localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

   logic [CNTW-1:0] cnt;
   logic            last;

   assign load = start & ~busy;
   assign step = busy;
   assign last = busy && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= last;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
   parameter int W          = 8,
   parameter bit PICK_FEWER = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   a_in,
   input  logic [W-1:0]   b_in,
   output logic           busy,
   output logic           done,
   output logic [2*W-1:0] product
);
   initial begin
      assert (W >= 4 && W <= 16) else $error("booth_seq_mul: W must be 4..16");
   end

   logic [W-1:0] sel_x, sel_y;
   logic         load, step;
   logic [W-1:0] u_q, v_q, x_q;
   logic         xm1_q;
   logic [W:0]   yp_q, yn_q;
   logic [W-1:0] u_n, v_n, x_n;
   logic         xm1_n;

   booth_operand_sel #(.W(W), .PICK_FEWER(PICK_FEWER)) u_sel (
      .opa(a_in), .opb(b_in), .mplier(sel_x), .mcand(sel_y)
   );

   booth_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .load(load), .step(step)
   );

   booth_step #(.W(W)) u_step (
      .u(u_q), .v(v_q), .x(x_q), .xm1(xm1_q),
      .y_pos(yp_q), .y_neg(yn_q),
      .u_nx(u_n), .v_nx(v_n), .x_nx(x_n), .xm1_nx(xm1_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_q   <= '0;
         v_q   <= '0;
         x_q   <= '0;
         xm1_q <= 1'b0;
         yp_q  <= '0;
         yn_q  <= '0;
      end else if (load) begin
         u_q   <= '0;
         v_q   <= '0;
         x_q   <= sel_x;
         xm1_q <= 1'b0;
         yp_q  <= {sel_y[W-1], sel_y};
         yn_q  <= (W+1)'(0) - {sel_y[W-1], sel_y};
      end else if (step) begin
         u_q   <= u_n;
         v_q   <= v_n;
         x_q   <= x_n;
         xm1_q <= xm1_n;
      end
   end

   assign product = {u_q, v_q};
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
   parameter int W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [W-1:0]   a_in,
   input logic [W-1:0]   b_in,
   input logic           busy,
   input logic           done,
   input logic [2*W-1:0] product
);
   localparam int CNTW = $clog2(W + 2);

   logic [CNTW-1:0] bcnt;
   logic [2*W-1:0]  exp_q;
   logic [2*W-1:0]  ae, be;

   assign ae = {{W{a_in[W-1]}}, a_in};
   assign be = {{W{b_in[W-1]}}, b_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt  <= '0;
         exp_q <= '0;
      end else if (start && !busy) begin
         bcnt  <= '0;
         exp_q <= ae * be;
      end else if (busy) begin
         bcnt <= bcnt + 1'b1;
      end
   end

   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r3_step_count: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bcnt == CNTW'(W) && !busy));
   a_r4_result: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == exp_q));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(product) && !done));
   a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && bcnt < CNTW'(W - 1)) |=> busy);
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
   .busy(busy), .done(done), .product(product)
);

// File: tb/tb_booth_seq_mul.sv
`timescale 1ns/1ps
module tb_booth_seq_mul;
   localparam int W = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   a_in = '0, b_in = '0;
   logic           busy, done, busy_p, done_p;
   logic [2*W-1:0] product, product_p;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   booth_seq_mul #(.W(W), .PICK_FEWER(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy), .done(done), .product(product)
   );

   booth_seq_mul #(.W(W), .PICK_FEWER(1'b0)) dut_plain (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy_p), .done(done_p), .product(product_p)
   );

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      int sa, sb;
      sa = (a[W-1]) ? int'(a) - (1 << W) : int'(a);
      sb = (b[W-1]) ? int'(b) - (1 << W) : int'(b);
      return (2*W)'(sa * sb);
   endfunction

   task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                        input logic [2*W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive a request at a negedge; returns at the negedge where done should be high.
   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
      bit ok_idle;
      a_in  = a;
      b_in  = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1 && busy_p === 1'b1, "R2 busy after accept",
            {7'd0, busy}, 8'd1);
      ok_idle = 1'b1;
      for (int k = 1; k < W; k++) begin
         @(negedge clk);
         if (done !== 1'b0 || busy !== 1'b1) ok_idle = 1'b0;
      end
      @(negedge clk);
      check(ok_idle && done === 1'b1 && busy === 1'b0, "R3 done after W steps",
            {6'd0, busy, done}, 8'd1);
   endtask

   task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] e;
      e = ref_mul(a, b);
      issue(a, b);
      check(product === e, "R4 product", product, e);
      check(product_p === e && done_p === 1'b1, "R8 variant match", product_p, e);
      @(negedge clk);
      check(done === 1'b0, "R5 done one cycle", {7'd0, done}, 8'd0);
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      logic [2*W-1:0] held;
      logic [2*W-1:0] e1, e2;
      bit             quiet;

      repeat (2) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && product === '0, "R1 reset state",
            product, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: the worked example 2 x -4 = 11111000
      run_one(4'b0010, 4'b1100);
      check(product === 8'b1111_1000, "R4 example 2x-4", product, 8'b1111_1000);

      // R4/R8 exhaustive sweep, covers 0, -1, +7, -8 and ties
      for (int ia = 0; ia < (1 << W); ia++)
         for (int ib = 0; ib < (1 << W); ib++)
            run_one(W'(ia), W'(ib));

      // R6: product held while idle with no start
      held  = product;
      quiet = 1'b1;
      repeat (6) begin
         @(negedge clk);
         if (product !== held || done !== 1'b0) quiet = 1'b0;
      end
      check(quiet, "R6 hold while idle", product, held);

      // R7: start during busy is ignored
      e1 = ref_mul(4'b1000, 4'b1000);
      a_in = 4'b1000; b_in = 4'b1000; start = 1'b1;
      @(negedge clk);
      a_in = 4'b0011; b_in = 4'b0101;
      @(negedge clk);
      start = 1'b0;
      for (int k = 2; k < W; k++) @(negedge clk);
      check(done === 1'b0, "R7 no early done", {7'd0, done}, 8'd0);
      @(negedge clk);
      check(done === 1'b1 && product === e1, "R7 operands kept", product, e1);

      // R9: start in the done cycle is accepted
      e2 = ref_mul(4'b0111, 4'b1001);
      issue(4'b0111, 4'b1001);
      check(product === e2, "R9 first result", product, e2);
      e1 = ref_mul(4'b1111, 4'b0110);
      issue(4'b1111, 4'b0110);
      check(product === e1, "R9 back-to-back result", product, e1);
      @(negedge clk);
      check(done === 1'b0, "R5 done one cycle", {7'd0, done}, 8'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule